// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches bytes between several parallel TDM streams that share one 125 µs frame. In each channel slot, every input stream presents one byte. The block stores that byte in a data memory. For each output stream and output channel, a connection entry picks a source stream and a source channel. The entry can also disable the slot, which then sends an idle 0xFF. The block has no serial framing. Its channel slots are one clock cycle long, and the `frameStart` pulse marks channel 0.

Each output slot uses one of two latency policies:

- **Constant delay** keeps a frame intact. Every byte leaves exactly two frames after the frame in which it arrived, at its new channel position. The delay is therefore 2 frames + n − m, where n is the output channel and m is the input channel.
- **Variable delay** gives the lowest latency. A source byte that is at least `GAP` channels ahead of the output slot goes out in the same frame. Any other source byte goes out one frame later. When the channel distance equals `GAP` exactly, the relative order of the two streams breaks the tie.

A chip-wide enable controls variable delay. When the enable is clear, every slot uses constant delay.

The block keeps three frames of input data in rotating memory banks. Each cycle it picks one bank per output stream, then registers the fetched byte onto the output.

Top module: `tdm_slot_switch`

## Requirements
- R1: While reset is active and after reset, `txData` is all 0xFF. After reset every connection entry is disabled, so outputs stay 0xFF until entries are programmed.
- R2: An output slot whose entry has the enable bit (`cmWrData[8]`) clear drives 0xFF.
- R3: The result for output channel n of frame G appears on `txData` in the cycle after the cycle in which the block's channel position equals n within frame G.
- R4: In constant delay, output channel n of frame G carries the byte received on the selected source stream and channel m in frame G−2.
- R5: When `varEnable` is low, every enabled slot behaves as in R4, whatever its mode bit says.
- R6: When `varEnable` is high and the entry's mode bit (`cmWrData[7]`) is 1, a slot with n − m > GAP (GAP = 7) carries the byte from frame G.
- R7: In variable delay, a slot with n − m < GAP carries the byte from frame G−1. This includes zero and negative differences.
- R8: In variable delay with n − m = GAP, the slot carries the frame G byte if the output stream index is greater than or equal to the source stream index. Otherwise it carries the frame G−1 byte.
- R9: When `varEnable` is high, an entry with mode bit 0 still uses constant delay. Slots in both modes can sit in the same frame.
- R10: Connection entries are written through the write port.
  - A write with `cmWrEn` high stores `cmWrData` at `cmWrAddr`.
  - Address bits [6:5] give the output stream and bits [4:0] give the output channel.
  - Data bits [4:0] give the source channel and bits [6:5] give the source stream.
  - The write takes effect from the next cycle.
- R11: A `frameStart` pulse sets the current channel to 0. The channel then advances by one per cycle, wraps after channel 31, and the three data banks rotate at each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one channel slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | High in the channel-0 slot of each frame |
| varEnable | input | 1 | Chip-wide permission for variable delay |
| rxData | input | NS*8 | One input byte per stream; stream s in bits [8s+7:8s] |
| cmWrEn | input | 1 | Connection entry write strobe |
| cmWrAddr | input | AW | Entry address {output stream, output channel} |
| cmWrData | input | CMW | Entry {enable, mode, source stream, source channel} |
| txData | output | NS*8 | One output byte per stream, registered |

## Verification
Input bytes for channel c of frame F are driven at a falling edge. The byte lands in memory at the next rising edge. At that same edge, the output register captures the result for output channel c of frame F. The bench therefore reads each output slot at the falling edge one cycle after it drove that slot's inputs, and computes the expected source frame (G, G−1 or G−2) from the channel difference, the stream order and the two mode controls. A connection write commits at the edge that follows it, so the bench skips the comparison for any slot fetched while an entry or `varEnable` was changing. Sweeping all 32 channel offsets on all four streams covers the tie at a difference of 7 in both stream orders, as well as negative differences.

// File: rtl/tdm_tsi_pkg.sv
`timescale 1ns/1ps
package tdm_tsi_pkg;

  // Three frames of history: the frame being written, the previous one, and
  // the one before it (needed by constant delay).
  localparam int NBANK = 3;

  typedef logic [1:0] bank_t;

  // Frame-level strobes from the control to the lookup and the datapath.
  typedef struct packed {
    bank_t wrBank;    // bank receiving the current frame
    bank_t prevBank;  // bank holding frame G-1
    bank_t oldBank;   // bank holding frame G-2
  } frame_ctl_t;

  function automatic bank_t bankAfter(bank_t b);
    return (b == bank_t'(NBANK - 1)) ? bank_t'(0) : b + bank_t'(1);
  endfunction

  function automatic bank_t bankBefore(bank_t b);
    return (b == bank_t'(0)) ? bank_t'(NBANK - 1) : b - bank_t'(1);
  endfunction

endpackage

// File: rtl/tdm_tsi_frame_ctrl.sv
`timescale 1ns/1ps
module tdm_tsi_frame_ctrl
  import tdm_tsi_pkg::*;
#(
  parameter  int NCH = 32,
  localparam int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  output logic [CW-1:0] curChan,
  output frame_ctl_t    ctl
);

  logic [CW-1:0] chanReg;
  bank_t         bankReg;
  bank_t         curBank;

  // The frame pulse forces channel 0 in its own slot and retires the
  // oldest bank so it can take the new frame.
  always_comb begin
    curChan      = frameStart ? '0 : chanReg;
    curBank      = frameStart ? bankAfter(bankReg) : bankReg;
    ctl.wrBank   = curBank;
    ctl.prevBank = bankBefore(curBank);
    ctl.oldBank  = bankAfter(curBank);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg <= '0;
      bankReg <= '0;
    end else begin
      chanReg <= (curChan == CW'(NCH - 1)) ? '0 : curChan + 1'b1;
      bankReg <= curBank;
    end
  end

endmodule

// File: rtl/tdm_tsi_conn_map.sv
`timescale 1ns/1ps
module tdm_tsi_conn_map
  import tdm_tsi_pkg::*;
#(
  parameter  int NS   = 4,
  parameter  int NCH  = 32,
  parameter  int GAP  = 7,
  localparam int SW   = $clog2(NS),
  localparam int CW   = $clog2(NCH),
  localparam int AW   = SW + CW,
  localparam int CMW  = CW + SW + 2,
  localparam int CMD  = 1 << AW
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmWrEn,
  input  logic [AW-1:0]  cmWrAddr,
  input  logic [CMW-1:0] cmWrData,
  input  logic           varEnable,
  input  logic [CW-1:0]  curChan,
  input  frame_ctl_t     ctl,
  output logic           rdEn     [NS],
  output bank_t          rdBank   [NS],
  output logic [SW-1:0]  rdStream [NS],
  output logic [CW-1:0]  rdChan   [NS]
);

  // Entry layout: [CMW-1] enable, [CW+SW] variable mode,
  // [CW+SW-1:CW] source stream, [CW-1:0] source channel.
  localparam int EN_BIT  = CMW - 1;
  localparam int VAR_BIT = CW + SW;

  logic [CMW-1:0] cmMem [CMD];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CMD; i++) cmMem[i] <= '0;
    end else if (cmWrEn) begin
      cmMem[cmWrAddr] <= cmWrData;
    end
  end

  logic [CMW-1:0] ent       [NS];
  logic           useVar    [NS];
  logic           sameFrame [NS];
  int             chanDiff  [NS];

  // Per output stream: look up the entry for the current slot and choose
  // the bank that holds the frame this slot must read.
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      ent[s]       = cmMem[{SW'(s), curChan}];
      chanDiff[s]  = int'(curChan) - int'(ent[s][CW-1:0]);
      useVar[s]    = varEnable & ent[s][VAR_BIT];
      sameFrame[s] = (chanDiff[s] > GAP) ||
                     ((chanDiff[s] == GAP) && (SW'(s) >= ent[s][CW+SW-1:CW]));
      rdEn[s]      = ent[s][EN_BIT];
      rdStream[s]  = ent[s][CW+SW-1:CW];
      rdChan[s]    = ent[s][CW-1:0];
      if (!useVar[s])        rdBank[s] = ctl.oldBank;
      else if (sameFrame[s]) rdBank[s] = ctl.wrBank;
      else                   rdBank[s] = ctl.prevBank;
    end
  end

endmodule

// File: rtl/tdm_tsi_datapath.sv
`timescale 1ns/1ps
module tdm_tsi_datapath
  import tdm_tsi_pkg::*;
#(
  parameter  int NS    = 4,
  parameter  int NCH   = 32,
  localparam int SW    = $clog2(NS),
  localparam int CW    = $clog2(NCH),
  localparam int DEPTH = NBANK * NS * NCH,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NS*8-1:0] rxData,
  input  logic [CW-1:0]  curChan,
  input  bank_t          wrBank,
  input  logic           rdEn     [NS],
  input  bank_t          rdBank   [NS],
  input  logic [SW-1:0]  rdStream [NS],
  input  logic [CW-1:0]  rdChan   [NS],
  output logic [NS*8-1:0] txData
);

  logic [7:0] dataMem [DEPTH];
  logic [7:0] fetched [NS];

  function automatic logic [IW-1:0] slotIdx(bank_t b, int s, int c);
    return IW'((int'(b) * NS + s) * NCH + c);
  endfunction

  // Every stream writes its byte for the current channel into the active bank.
  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++)
      dataMem[slotIdx(wrBank, s, int'(curChan))] <= rxData[s*8 +: 8];
  end

  always_comb begin
    for (int s = 0; s < NS; s++)
      fetched[s] = rdEn[s]
                 ? dataMem[slotIdx(rdBank[s], int'(rdStream[s]), int'(rdChan[s]))]
                 : 8'hFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '1;
    end else begin
      for (int s = 0; s < NS; s++) txData[s*8 +: 8] <= fetched[s];
    end
  end

endmodule

// File: rtl/tdm_slot_switch.sv
`timescale 1ns/1ps
module tdm_slot_switch
  import tdm_tsi_pkg::*;
#(
  parameter  int NS  = 4,
  parameter  int NCH = 32,
  parameter  int GAP = 7,
  localparam int SW  = $clog2(NS),
  localparam int CW  = $clog2(NCH),
  localparam int AW  = SW + CW,
  localparam int CMW = CW + SW + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic            varEnable,
  input  logic [NS*8-1:0] rxData,
  input  logic            cmWrEn,
  input  logic [AW-1:0]   cmWrAddr,
  input  logic [CMW-1:0]  cmWrData,
  output logic [NS*8-1:0] txData
);

  logic [CW-1:0] curChan;
  frame_ctl_t    ctl;
  logic          rdEn     [NS];
  bank_t         rdBank   [NS];
  logic [SW-1:0] rdStream [NS];
  logic [CW-1:0] rdChan   [NS];

  tdm_tsi_frame_ctrl #(.NCH(NCH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .curChan    (curChan),
    .ctl        (ctl)
  );

  tdm_tsi_conn_map #(.NS(NS), .NCH(NCH), .GAP(GAP)) u_map (
    .clk       (clk),
    .rstN      (rstN),
    .cmWrEn    (cmWrEn),
    .cmWrAddr  (cmWrAddr),
    .cmWrData  (cmWrData),
    .varEnable (varEnable),
    .curChan   (curChan),
    .ctl       (ctl),
    .rdEn      (rdEn),
    .rdBank    (rdBank),
    .rdStream  (rdStream),
    .rdChan    (rdChan)
  );

  tdm_tsi_datapath #(.NS(NS), .NCH(NCH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .rxData   (rxData),
    .curChan  (curChan),
    .wrBank   (ctl.wrBank),
    .rdEn     (rdEn),
    .rdBank   (rdBank),
    .rdStream (rdStream),
    .rdChan   (rdChan),
    .txData   (txData)
  );

endmodule

// File: rtl/tdm_slot_switch_chk.sv
`timescale 1ns/1ps
module tdm_slot_switch_chk
  import tdm_tsi_pkg::*;
#(
  parameter  int NS  = 4,
  parameter  int NCH = 32,
  parameter  int GAP = 7,
  localparam int CW  = $clog2(NCH)
) (
  input logic            clk,
  input logic            rstN,
  input logic            frameStart,
  input logic [CW-1:0]   curChan,
  input frame_ctl_t      ctl,
  input logic            rdEn   [NS],
  input bank_t           rdBank [NS],
  input logic [CW-1:0]   rdChan [NS],
  input logic [NS*8-1:0] txData
);

  AST_FRAME_NEXT_CHAN: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (frameStart || curChan == CW'(1))); // R11

  AST_CHAN_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && curChan != CW'(NCH - 1)) |=>
      (frameStart || curChan == $past(curChan) + 1'b1)); // R11

  AST_BANK_AGE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> ctl.oldBank == $past(ctl.prevBank)); // R4

  for (genvar s = 0; s < NS; s++) begin : g_lane
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !rdEn[s] |=> txData[s*8 +: 8] == 8'hFF); // R2

    AST_SAME_FRAME_READY: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn[s] && rdBank[s] == ctl.wrBank) |->
        (int'(rdChan[s]) + GAP <= int'(curChan))); // R6
  end

endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.NS(NS), .NCH(NCH), .GAP(GAP)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .curChan    (curChan),
  .ctl        (ctl),
  .rdEn       (rdEn),
  .rdBank     (rdBank),
  .rdChan     (rdChan),
  .txData     (txData)
);

// File: tb/tdm_slot_switch_tb.sv
`timescale 1ns/1ps
module tdm_slot_switch_tb;

  localparam int NS  = 4;
  localparam int NCH = 32;
  localparam int GAP = 7;
  localparam int SW  = 2;
  localparam int CW  = 5;
  localparam int AW  = SW + CW;
  localparam int CMW = CW + SW + 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameStart = 1'b0;
  logic            varEnable = 1'b0;
  logic [NS*8-1:0] rxData = '0;
  logic            cmWrEn = 1'b0;
  logic [AW-1:0]   cmWrAddr = '0;
  logic [CMW-1:0]  cmWrData = '0;
  logic [NS*8-1:0] txData;

  always #2.5 clk = ~clk;

  tdm_slot_switch #(.NS(NS), .NCH(NCH), .GAP(GAP)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .varEnable  (varEnable),
    .rxData     (rxData),
    .cmWrEn     (cmWrEn),
    .cmWrAddr   (cmWrAddr),
    .cmWrData   (cmWrData),
    .txData     (txData)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int frameNo = -1;
  int prevF = 0;
  int prevC = 0;
  bit prevValid = 0;
  bit done = 0;
  bit phaseDefault = 0;
  bit mirVarEn = 0;
  bit cfgEn   [NS][NCH];
  bit cfgVar  [NS][NCH];
  int cfgSrcS [NS][NCH];
  int cfgSrcC [NS][NCH];

  function automatic logic [7:0] pat(int f, int s, int c);
    return 8'((c * 7 + s * 61 + f * 29) & 255);
  endfunction

  task automatic checkEq(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // Every slot check also covers R3 (result one cycle after the slot),
  // R10 (entry field decode) and R11 (frame alignment and channel wrap).
  task automatic checkSlot(int g, int n);
    for (int s = 0; s < NS; s++) begin
      int srcF;
      int d;
      string tag;
      if (!cfgEn[s][n]) begin
        checkEq($sformatf("%s s%0d n%0d frame%0d", phaseDefault ? "R1" : "R2", s, n, g),
                txData[s*8 +: 8], 8'hFF);
      end else begin
        d = n - cfgSrcC[s][n];
        if (!(mirVarEn && cfgVar[s][n])) begin
          srcF = g - 2;
          tag = !mirVarEn ? (cfgVar[s][n] ? "R5" : "R4") : "R9";
        end else if (d > GAP || (d == GAP && s >= cfgSrcS[s][n])) begin
          srcF = g;
          tag = (d == GAP) ? "R8" : "R6";
        end else begin
          srcF = g - 1;
          tag = (d == GAP) ? "R8" : "R7";
        end
        if (srcF >= 0)
          checkEq($sformatf("%s s%0d n%0d m%0d src%0d frame%0d", tag, s, n,
                            cfgSrcC[s][n], cfgSrcS[s][n], g),
                  txData[s*8 +: 8], pat(srcF, cfgSrcS[s][n], cfgSrcC[s][n]));
      end
    end
  endtask

  task automatic stepCycle(bit chk);
    @(negedge clk);
    if (prevValid) checkSlot(prevF, prevC);
    if (cyc % NCH == 0) frameNo++;
    frameStart = (cyc % NCH == 0);
    for (int s = 0; s < NS; s++) rxData[s*8 +: 8] = pat(frameNo, s, cyc % NCH);
    prevF = frameNo;
    prevC = cyc % NCH;
    prevValid = chk;
    cyc++;
  endtask

  // R10: address {stream, channel}; data {enable, mode, src stream, src channel}
  task automatic writeEntry(int s, int n, bit en, bit v, int ss, int sc);
    prevValid = 0;
    cmWrEn = 1'b1;
    cmWrAddr = {SW'(ss * 0 + s), CW'(n)};
    cmWrData = {en, v, SW'(ss), CW'(sc)};
    cfgEn[s][n] = en;
    cfgVar[s][n] = v;
    cfgSrcS[s][n] = ss;
    cfgSrcC[s][n] = sc;
    stepCycle(0);
    cmWrEn = 1'b0;
  endtask

  task automatic setVarEn(bit v);
    prevValid = 0;
    varEnable = v;
    mirVarEn = v;
    stepCycle(0);
  endtask

  task automatic runFrames(int k);
    repeat (k * NCH) stepCycle(1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    for (int s = 0; s < NS; s++)
      checkEq($sformatf("R1 reset idle s%0d", s), txData[s*8 +: 8], 8'hFF);
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NS; s++)
      checkEq($sformatf("R1 after reset s%0d", s), txData[s*8 +: 8], 8'hFF);

    // R1: unprogrammed entries keep every slot idle
    phaseDefault = 1;
    runFrames(3);
    phaseDefault = 0;

    // R4/R5: global variable delay off, mode bits mixed, some slots off (R2)
    setVarEn(0);
    for (int s = 0; s < NS; s++)
      for (int n = 0; n < NCH; n++)
        writeEntry(s, n, (s + n) % 7 != 0, n % 3 == 0, (s + 1) % NS, (n * 5 + 3) % NCH);
    runFrames(4);

    // R9 with R6/R7: global enable on, per-slot mode mixed
    setVarEn(1);
    for (int s = 0; s < NS; s++)
      for (int n = 0; n < NCH; n++)
        writeEntry(s, n, n % 5 != 0, n[0], (s + 2) % NS, (n * 3 + s * 11) % NCH);
    runFrames(3);

    // R6/R7/R8: every channel offset, both stream orders, all variable
    for (int off = 0; off < NCH; off++) begin
      for (int s = 0; s < NS; s++)
        for (int n = 0; n < NCH; n++)
          writeEntry(s, n, 1'b1, 1'b1, NS - 1 - s, (n - off + NCH) % NCH);
      runFrames(2);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule